// File: doc/BRIEF.md
# PWM Fault Protection Unit

This block stands between the fault-sense pins of a motor or power stage and the pulse-width outputs of one PWM channel group. It watches four fault inputs. Each input has its own active level and passes through a shared-setting digital filter, with an optional pulse stretcher and an optional unfiltered bypass path. Each of the three outputs (A, B, X) has its own mask that selects which faults can switch it off. A disabled output is driven to a programmed safe state: low, high or high-impedance. Polarity and deadtime are applied further down the chain, outside this block.

Once a fault has been seen, the block holds the affected outputs off until the fault's clearing mode lets them go. The three clearing modes are automatic, manual, and manual with safety. Release always happens on a PWM half-cycle strobe, a full-cycle strobe, or either, as the fault's recovery selection says. A sticky flag per fault records each new fault and, when enabled, raises the interrupt line. All configuration arrives on static input ports that a register file upstream drives.

Top module: `pwm_fault_guard`

## Requirements
- R1: Each fault has a level select `lvl_high[i]`. With 1, a high pin means fault. With 0, a low pin means fault.
- R2: With `filt_period` = 0 and stretching off, `fault_status[i]` equals the level-corrected pin value of the previous clock.
- R3: With `filt_period` = P > 0, the corrected pin is sampled once every P clocks. `fault_status[i]` changes only after `filt_count`+1 consecutive samples all differ from its current value. A pulse shorter than P·(`filt_count`) clocks is never accepted.
- R4: With `stretch_en` = 1, a fault that is active for a single clock is seen by the filter for two clocks.
- R5: With `comb_en[i]` = 1, an active corrected pin disables the mapped outputs in the same cycle, without waiting for the filter.
- R6: Output o (0 = A, 1 = B, 2 = X) is disabled while any fault i is active or held and bit `dis_map[o*4+i]` is 1.
- R7: `safe_state[2o+1:2o]` sets the state of a disabled output: 00 drives 0, 01 drives 1, 10 and 11 tristate (`out_drive` = 0). An output that is not disabled has `out_level` = 0 and `out_drive` = 1.
- R8: `fault_flag[i]` sets on the clock after a fault becomes active. It stays set until a clock with `flag_clr[i]` = 1, and a new fault in that same clock wins over the clear. `irq` is the OR of `fault_flag & irq_en`.
- R9: With clearing mode 0 (automatic), the hold is released at the selected recovery strobe once the fault is inactive, whether or not the flag has been cleared.
- R10: With clearing mode 1 (manual), the hold is released at a recovery strobe after the flag has been cleared, even if the pin is still active. The output then returns as soon as the fault goes inactive.
- R11: With clearing mode 2 (manual with safety), release needs three things: the fault inactive, the flag cleared, and a recovery strobe that comes after both.
- R12: `recov_sel[2i+1:2i]` selects the release strobe: 0 means never, 1 means half cycle, 2 means full cycle, 3 means either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_pin | input | 4 | Raw fault inputs |
| cyc_half | input | 1 | PWM half-cycle strobe |
| cyc_full | input | 1 | PWM full-cycle strobe |
| lvl_high | input | 4 | Per-fault active level, 1 = high |
| filt_period | input | 8 | Filter sample period in clocks, 0 = bypass |
| filt_count | input | 3 | Extra agreeing samples needed |
| stretch_en | input | 1 | Widen single-clock faults |
| comb_en | input | 4 | Per-fault unfiltered disable path |
| clr_mode | input | 8 | Per-fault clearing mode, 2 bits each |
| recov_sel | input | 8 | Per-fault recovery strobe, 2 bits each |
| dis_map | input | 12 | Per-output fault mask, 4 bits each |
| safe_state | input | 6 | Per-output safe state, 2 bits each |
| irq_en | input | 4 | Per-fault interrupt enable |
| flag_clr | input | 4 | Per-fault flag clear strobe |
| out_disable | output | 3 | Output is switched off |
| out_level | output | 3 | Forced level of a disabled output |
| out_drive | output | 3 | 0 = tristate the output |
| fault_status | output | 4 | Filtered fault state |
| fault_flag | output | 4 | Sticky fault flags |
| irq | output | 1 | Interrupt request |

## Verification
A hold register stuck high keeps `out_disable` set after the recovery strobe. A hold that never sets lets the output come back as soon as the pin clears. Either error shows at the ports on the first strobe after the fault is removed. A wrong filter run counter shows as a short pulse reaching `fault_status`, or a long pulse missing it, within about P·(`filt_count`+2) clocks. Flag and clear-mode errors appear one clock after the flag clear or the strobe, as an output that returns too early or stays off.

// File: rtl/pfg_pkg.sv
// Shared encodings of the fault protection unit.
// Assumes: 2-bit fields per fault for clearing and recovery selection.
package pfg_pkg;
    typedef enum logic [1:0] {
        CLR_AUTO   = 2'd0,
        CLR_MANUAL = 2'd1,
        CLR_SAFE   = 2'd2,
        CLR_SAFE_X = 2'd3
    } clr_mode_e;

    localparam logic [1:0] SAFE_LOW  = 2'b00;
    localparam logic [1:0] SAFE_HIGH = 2'b01;

    // Release strobe for a recovery selection: bit 0 half cycle, bit 1 full cycle
    function automatic logic recov_strobe(input logic [1:0] sel, input logic half, input logic full);
        return (sel[0] & half) | (sel[1] & full);
    endfunction
endpackage

// File: rtl/pfg_input_filter.sv
// Per-fault front end: level correction, optional one-clock stretch and
// count/period glitch filter. Assumes configuration is quasi-static.
module pfg_input_filter #(
    parameter int PW = 8,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin,
    input  logic          lvl_high,
    input  logic          stretch_en,
    input  logic [PW-1:0] period,
    input  logic [CW-1:0] count,
    output logic          raw_act,
    output logic          filt
);
    logic          act_d;
    logic          samp;
    logic          bypass;
    logic          tick;
    logic [PW-1:0] pre_q;
    logic [CW-1:0] run_q;
    logic          filt_q;

    assign raw_act = ~(pin ^ lvl_high);
    assign samp    = raw_act | (stretch_en & act_d);
    assign bypass  = (period == '0);
    assign tick    = !bypass && (pre_q >= period - PW'(1));
    assign filt    = filt_q;

    // Remember last corrected level for the stretcher
    always_ff @(posedge clk) begin
        if (!rst_n) act_d <= 1'b0;
        else        act_d <= raw_act;
    end

    // Sample period prescaler
    always_ff @(posedge clk) begin
        if (!rst_n || bypass || tick) pre_q <= '0;
        else                          pre_q <= pre_q + PW'(1);
    end

    // Accept a new level after count+1 consecutive differing samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            run_q  <= '0;
        end else if (bypass) begin
            filt_q <= samp;
            run_q  <= '0;
        end else if (tick) begin
            if (samp == filt_q) begin
                run_q <= '0;
            end else if (run_q == count) begin
                filt_q <= samp;
                run_q  <= '0;
            end else begin
                run_q <= run_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/pfg_fault_track.sv
// Per-fault sticky flag and output hold with clearing/recovery control.
// Assumes cyc_half/cyc_full are single-clock strobes.
module pfg_fault_track
    import pfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       det,
    input  logic [1:0] mode,
    input  logic [1:0] recov,
    input  logic       cyc_half,
    input  logic       cyc_full,
    input  logic       flag_clr,
    output logic       flag,
    output logic       hold
);
    logic      det_d;
    logic      rise;
    logic      strobe;
    logic      set_hold;
    logic      release_hold;
    clr_mode_e mode_e;

    assign mode_e = clr_mode_e'(mode);
    assign rise   = det & ~det_d;
    assign strobe = recov_strobe(recov, cyc_half, cyc_full);

    // Select hold set and release conditions from the clearing mode
    always_comb begin
        unique case (mode_e)
            CLR_AUTO: begin
                set_hold     = det;
                release_hold = strobe & ~det;
            end
            CLR_MANUAL: begin
                set_hold     = rise;
                release_hold = strobe & ~flag;
            end
            default: begin
                set_hold     = det;
                release_hold = strobe & ~det & ~flag;
            end
        endcase
    end

    // Previous detection level for edge finding
    always_ff @(posedge clk) begin
        if (!rst_n) det_d <= 1'b0;
        else        det_d <= det;
    end

    // Sticky flag, a new fault wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= rise | (flag & ~flag_clr);
    end

    // Output hold, set wins over release
    always_ff @(posedge clk) begin
        if (!rst_n) hold <= 1'b0;
        else        hold <= set_hold | (hold & ~release_hold);
    end
endmodule

// File: rtl/pfg_output_gate.sv
// Per-output disable decision and safe-state drive.
// Assumes live is already the OR of active and held faults.
module pfg_output_gate
    import pfg_pkg::*;
#(
    parameter int NF = 4
) (
    input  logic [NF-1:0] map,
    input  logic [NF-1:0] live,
    input  logic [1:0]    state,
    output logic          dis,
    output logic          level,
    output logic          drive
);
    // Disable when any masked fault is live, then apply the safe state
    always_comb begin
        dis   = |(map & live);
        level = dis && (state == SAFE_HIGH);
        drive = !(dis && state[1]);
    end
endmodule

// File: rtl/pwm_fault_guard.sv
// Fault protection unit for one PWM channel group: NF fault inputs,
// NO outputs. Assumes all configuration ports come from a register file.
module pwm_fault_guard #(
    parameter int NF = 4,
    parameter int NO = 3,
    parameter int PW = 8,
    parameter int CW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NF-1:0]    fault_pin,
    input  logic             cyc_half,
    input  logic             cyc_full,
    input  logic [NF-1:0]    lvl_high,
    input  logic [PW-1:0]    filt_period,
    input  logic [CW-1:0]    filt_count,
    input  logic             stretch_en,
    input  logic [NF-1:0]    comb_en,
    input  logic [2*NF-1:0]  clr_mode,
    input  logic [2*NF-1:0]  recov_sel,
    input  logic [NO*NF-1:0] dis_map,
    input  logic [2*NO-1:0]  safe_state,
    input  logic [NF-1:0]    irq_en,
    input  logic [NF-1:0]    flag_clr,
    output logic [NO-1:0]    out_disable,
    output logic [NO-1:0]    out_level,
    output logic [NO-1:0]    out_drive,
    output logic [NF-1:0]    fault_status,
    output logic [NF-1:0]    fault_flag,
    output logic             irq
);
    logic [NF-1:0] raw_act;
    logic [NF-1:0] det_now;
    logic [NF-1:0] held;
    logic [NF-1:0] live;

    // One front end and one tracker per fault input
    for (genvar i = 0; i < NF; i++) begin : g_fault
        pfg_input_filter #(.PW(PW), .CW(CW)) u_filt (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin        (fault_pin[i]),
            .lvl_high   (lvl_high[i]),
            .stretch_en (stretch_en),
            .period     (filt_period),
            .count      (filt_count),
            .raw_act    (raw_act[i]),
            .filt       (fault_status[i])
        );

        assign det_now[i] = fault_status[i] | (comb_en[i] & raw_act[i]);

        pfg_fault_track u_track (
            .clk      (clk),
            .rst_n    (rst_n),
            .det      (det_now[i]),
            .mode     (clr_mode[2*i +: 2]),
            .recov    (recov_sel[2*i +: 2]),
            .cyc_half (cyc_half),
            .cyc_full (cyc_full),
            .flag_clr (flag_clr[i]),
            .flag     (fault_flag[i]),
            .hold     (held[i])
        );
    end

    assign live = det_now | held;

    // One gate per output
    for (genvar o = 0; o < NO; o++) begin : g_out
        pfg_output_gate #(.NF(NF)) u_gate (
            .map   (dis_map[o*NF +: NF]),
            .live  (live),
            .state (safe_state[2*o +: 2]),
            .dis   (out_disable[o]),
            .level (out_level[o]),
            .drive (out_drive[o])
        );
    end

    assign irq = |(fault_flag & irq_en);
endmodule

// File: rtl/pfg_checker.sv
// Property checker for pwm_fault_guard, bound to every instance.
// Assumes it sees the top's ports plus det_now and held.
module pfg_checker #(
    parameter int NF = 4,
    parameter int NO = 3,
    parameter int PW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NF-1:0]    fault_pin,
    input logic [NF-1:0]    lvl_high,
    input logic [PW-1:0]    filt_period,
    input logic             stretch_en,
    input logic [NO*NF-1:0] dis_map,
    input logic [2*NF-1:0]  recov_sel,
    input logic             cyc_half,
    input logic             cyc_full,
    input logic [NF-1:0]    flag_clr,
    input logic [NF-1:0]    det_now,
    input logic [NF-1:0]    held,
    input logic [NO-1:0]    out_disable,
    input logic [NO-1:0]    out_drive,
    input logic [NF-1:0]    fault_status,
    input logic [NF-1:0]    fault_flag
);
    // R2
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_period == '0 && !stretch_en) |=> (fault_status == $past(~(fault_pin ^ lvl_high))));

    for (genvar i = 0; i < NF; i++) begin : g_f
        // R8
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(fault_flag[i]) |-> $past(flag_clr[i]));
        // R8
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fault_flag[i]) |-> $past(det_now[i]));
        // R12
        release_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(held[i]) |-> $past(cyc_half || cyc_full));
        // R12
        never_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (recov_sel[2*i +: 2] == 2'b00 && held[i]) |=> held[i]);
    end

    for (genvar o = 0; o < NO; o++) begin : g_o
        // R6
        mapped_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|(dis_map[o*NF +: NF] & det_now)) |-> out_disable[o]);
        // R7
        tristate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !out_drive[o] |-> out_disable[o]);
    end
endmodule

bind pwm_fault_guard pfg_checker #(.NF(NF), .NO(NO), .PW(PW)) u_chk (.*);

// File: tb/tb_pwm_fault_guard.sv
module tb_pwm_fault_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 4;
    localparam int NO = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   fault_pin = 4'h0;
    logic         cyc_half = 1'b0;
    logic         cyc_full = 1'b0;
    logic [3:0]   lvl_high = 4'hF;
    logic [7:0]   filt_period = 8'd0;
    logic [2:0]   filt_count = 3'd0;
    logic         stretch_en = 1'b0;
    logic [3:0]   comb_en = 4'h0;
    logic [7:0]   clr_mode = 8'h00;
    logic [7:0]   recov_sel = 8'hFF;
    logic [11:0]  dis_map = 12'hFFF;
    logic [5:0]   safe_state = 6'h00;
    logic [3:0]   irq_en = 4'h0;
    logic [3:0]   flag_clr = 4'h0;
    logic [2:0]   out_disable, out_level, out_drive;
    logic [3:0]   fault_status, fault_flag;
    logic         irq;

    int checks = 0;
    int errors = 0;

    // pins, level, map, safe state, expected disable, level, drive
    localparam logic [34:0] VEC [6] = '{
        {4'b0001, 4'b1111, 12'hFFF, 6'b000000, 3'b111, 3'b000, 3'b111},
        {4'b0010, 4'b1111, 12'h421, 6'b000101, 3'b010, 3'b010, 3'b111},
        {4'b0000, 4'b1011, 12'h421, 6'b100000, 3'b100, 3'b000, 3'b011},
        {4'b1000, 4'b1111, 12'h421, 6'b111111, 3'b000, 3'b000, 3'b111},
        {4'b1001, 4'b1111, 12'h881, 6'b110100, 3'b111, 3'b010, 3'b011},
        {4'b0110, 4'b1001, 12'hFFF, 6'b000000, 3'b000, 3'b000, 3'b111}
    };

    pwm_fault_guard #(.NF(NF), .NO(NO)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_half();
        @(negedge clk) cyc_half = 1'b1;
        @(negedge clk) cyc_half = 1'b0;
    endtask

    task automatic pulse_full();
        @(negedge clk) cyc_full = 1'b1;
        @(negedge clk) cyc_full = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) flag_clr = 4'hF;
        @(negedge clk) flag_clr = 4'h0;
    endtask

    // Return every fault to idle and release all holds
    task automatic recover();
        @(negedge clk);
        fault_pin = ~lvl_high;
        clr_mode  = 8'h00;
        recov_sel = 8'hFF;
        comb_en   = 4'h0;
        tick(50);
        pulse_half();
        pulse_clr();
        tick(2);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic seen;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R6 reset disable", {5'd0, out_disable}, 8'h00);
        chk("R7 reset drive", {5'd0, out_drive}, 8'h07);
        chk("R8 reset flags", {4'd0, fault_flag}, 8'h00);
        chk("R8 reset irq", {7'd0, irq}, 8'h00);

        // Table walk: R1 level select, R6 mapping, R7 safe states
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            lvl_high   = VEC[k][30:27];
            dis_map    = VEC[k][26:15];
            safe_state = VEC[k][14:9];
            recover();
            fault_pin = VEC[k][34:31];
            tick(2);
            chk("R1/R6 table disable", {5'd0, out_disable}, {5'd0, VEC[k][8:6]});
            chk("R7 table level", {5'd0, out_level}, {5'd0, VEC[k][5:3]});
            chk("R7 table drive", {5'd0, out_drive}, {5'd0, VEC[k][2:0]});
            recover();
        end
        lvl_high = 4'hF; dis_map = 12'hFFF; safe_state = 6'h00;
        recover();

        // R2 bypass and R4 stretch
        fault_pin[0] = 1'b1;
        tick(1);
        chk("R2 bypass follows", {4'd0, fault_status}, 8'h01);
        fault_pin[0] = 1'b0;
        tick(1);
        chk("R2 bypass single clock", {4'd0, fault_status}, 8'h00);
        recover();
        stretch_en = 1'b1;
        fault_pin[0] = 1'b1;
        tick(1);
        fault_pin[0] = 1'b0;
        tick(1);
        chk("R4 stretched second clock", {4'd0, fault_status}, 8'h01);
        tick(1);
        chk("R4 stretch ends", {4'd0, fault_status}, 8'h00);
        stretch_en = 1'b0;
        recover();

        // R3 filter rejects short, accepts long
        filt_period = 8'd4; filt_count = 3'd2;
        recover();
        seen = 1'b0;
        fault_pin[0] = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            seen |= fault_status[0] | out_disable[0];
        end
        fault_pin[0] = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            seen |= fault_status[0] | out_disable[0];
        end
        chk("R3 short pulse rejected", {7'd0, seen}, 8'h00);
        fault_pin[0] = 1'b1;
        tick(20);
        chk("R3 long pulse accepted", {4'd0, fault_status}, 8'h01);
        fault_pin[0] = 1'b0;
        tick(20);
        chk("R3 release filtered", {4'd0, fault_status}, 8'h00);
        recover();

        // R5 unfiltered path
        filt_period = 8'd8; filt_count = 3'd3;
        recover();
        @(negedge clk) fault_pin[0] = 1'b1;
        #1 chk("R5 no path, no disable", {5'd0, out_disable}, 8'h00);
        comb_en[0] = 1'b1;
        #1 chk("R5 path disables at once", {5'd0, out_disable}, 8'h07);
        filt_period = 8'd0; filt_count = 3'd0;
        recover();

        // R9 automatic clearing, R12 half-only selection, R8 sticky flag and irq
        clr_mode[1:0] = 2'd0; recov_sel[1:0] = 2'd1; irq_en = 4'h1;
        fault_pin[0] = 1'b1;
        tick(3);
        chk("R8 flag set", {4'd0, fault_flag}, 8'h01);
        chk("R8 irq", {7'd0, irq}, 8'h01);
        fault_pin[0] = 1'b0;
        tick(3);
        chk("R9 held after clear pin", {5'd0, out_disable}, 8'h07);
        pulse_full();
        chk("R12 full ignored for half", {5'd0, out_disable}, 8'h07);
        pulse_half();
        chk("R9 auto release on half", {5'd0, out_disable}, 8'h00);
        chk("R8 flag stays", {4'd0, fault_flag}, 8'h01);
        irq_en = 4'h0;
        #1 chk("R8 irq masked", {7'd0, irq}, 8'h00);
        pulse_clr();
        chk("R8 flag cleared", {4'd0, fault_flag}, 8'h00);

        // R12 selection 0 never releases
        recov_sel[1:0] = 2'd0;
        fault_pin[0] = 1'b1;
        tick(3);
        fault_pin[0] = 1'b0;
        tick(2);
        pulse_half();
        pulse_full();
        chk("R12 never release", {5'd0, out_disable}, 8'h07);
        recov_sel[1:0] = 2'd3;
        pulse_half();
        chk("R12 either releases", {5'd0, out_disable}, 8'h00);
        recover();

        // R11 manual with safety
        clr_mode[1:0] = 2'd2; recov_sel[1:0] = 2'd2;
        fault_pin[0] = 1'b1;
        tick(3);
        fault_pin[0] = 1'b0;
        tick(3);
        pulse_full();
        chk("R11 flag blocks release", {5'd0, out_disable}, 8'h07);
        pulse_clr();
        chk("R11 waits strobe", {5'd0, out_disable}, 8'h07);
        pulse_full();
        chk("R11 release", {5'd0, out_disable}, 8'h00);
        fault_pin[0] = 1'b1;
        tick(3);
        pulse_clr();
        pulse_full();
        fault_pin[0] = 1'b0;
        tick(2);
        chk("R11 pin must clear before strobe", {5'd0, out_disable}, 8'h07);
        pulse_full();
        chk("R11 later release", {5'd0, out_disable}, 8'h00);
        recover();

        // R10 manual without safety
        clr_mode[1:0] = 2'd1; recov_sel[1:0] = 2'd3;
        fault_pin[0] = 1'b1;
        tick(3);
        pulse_half();
        fault_pin[0] = 1'b0;
        tick(2);
        chk("R10 uncleared flag holds", {5'd0, out_disable}, 8'h07);
        pulse_clr();
        chk("R10 clear needs strobe", {5'd0, out_disable}, 8'h07);
        pulse_half();
        chk("R10 release", {5'd0, out_disable}, 8'h00);
        fault_pin[0] = 1'b1;
        tick(3);
        pulse_clr();
        pulse_half();
        chk("R10 active pin still disables", {5'd0, out_disable}, 8'h07);
        fault_pin[0] = 1'b0;
        tick(2);
        chk("R10 returns without strobe", {5'd0, out_disable}, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule